// File: doc/BRIEF.md
# Dual-Trigger Timer Capture Unit

A free-running up-counter with two capture registers. Each register takes a snapshot of the counter when one of two external trigger inputs, A and B, shows a valid edge. The edges arrive already qualified, as single-cycle pulses. The count clock also arrives pre-divided, as two strobes: a rising-phase strobe, which advances the counter, and a falling-phase strobe, which marks the capture instant. A trigger pulse is held until the next falling-phase strobe. The snapshot is taken on that strobe. The interrupt for that snapshot is issued one count-clock phase later, on the following rising-phase strobe.

Capture register 1 always follows input A. In normal mode, capture register 0 follows input B. In reverse-phase mode, capture register 0 instead follows the opposite-phase edge of input A. That capture raises no interrupt. An edge on B then no longer loads anything but still raises interrupt 0, which serves as a plain external interrupt. When the edge of A also serves as the count clock, any capture triggered by A is unreliable, so the block suppresses it. While the run enable is low, the counter sits at zero and every trigger is ignored.

Top module: `dual_capture_timer`

## Requirements
- R1: While `run_i` is low, `count_o` reads 0 in the next cycle. While `run_i` is high, it rises by 1 in the cycle after each `tick_rise_i` strobe, holds otherwise, and wraps from 0xFFFF to 0.
- R2: An `edge_a_i` pulse with `run_i` high is held until the first cycle with `tick_fall_i` high. This may be the same cycle as the pulse. In that cycle `count_o` is copied into `cap1_o`, which shows the new value in the next cycle.
- R3: With `rev_mode_i` low, an `edge_b_i` pulse loads `cap0_o` in the same way.
- R4: Each capture interrupt (`irq0_o` for register 0, `irq1_o` for register 1) is a one-cycle pulse. It is high in the cycle right after the first `tick_rise_i` strobe that follows the capture strobe, and never in the cycle of the capture itself.
- R5: If a register is captured twice before its interrupt is issued, the register keeps the second value and exactly one interrupt pulse results.
- R6: With `rev_mode_i` high, an `edge_a_rev_i` pulse loads `cap0_o` on the falling-phase strobe and raises no `irq0_o`. With `rev_mode_i` low, `edge_a_rev_i` has no effect.
- R7: With `rev_mode_i` high, an `edge_b_i` pulse leaves `cap0_o` unchanged but still raises `irq0_o`, with the timing of R4.
- R8: While `run_i` is low, trigger pulses are discarded and raise no interrupt, even after `run_i` returns high. Both capture registers hold their values.
- R9: With `a_is_clk_i` high, pulses on `edge_a_i` and `edge_a_rev_i` load no register and raise no interrupt. B-triggered events still work.
- R10: After reset, `count_o`, `cap0_o`, `cap1_o`, `irq0_o` and `irq1_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Counter run enable; low clears and stops |
| tick_rise_i | input | 1 | Count-clock rising-phase strobe; advances counter |
| tick_fall_i | input | 1 | Count-clock falling-phase strobe; capture instant |
| edge_a_i | input | 1 | Qualified edge pulse of input A |
| edge_a_rev_i | input | 1 | Qualified opposite-phase edge pulse of input A |
| edge_b_i | input | 1 | Qualified edge pulse of input B |
| rev_mode_i | input | 1 | Register 0 captures on the reverse-phase edge of A |
| a_is_clk_i | input | 1 | Input A edge drives the count clock; A captures inhibited |
| count_o | output | 16 | Counter value |
| cap0_o | output | 16 | Capture register 0 |
| cap1_o | output | 16 | Capture register 1 |
| irq0_o | output | 1 | Interrupt for register 0 / external B event |
| irq1_o | output | 1 | Interrupt for register 1 |

## Verification
A capture lands on the clock edge that samples the falling-phase strobe, and the captured value is readable one cycle later. The interrupt follows on the edge that samples the next rising-phase strobe. With the bench's strobe spacing of eight cycles, that edge comes four cycles after the capture. The driver records the capture edge, reads the expected count from its own counter model, and queues the value together with the exact cycle in which the interrupt is due. The monitor runs on falling clock edges, between active edges. It flags any interrupt that arrives off its due cycle or without a queued entry, and any entry whose due cycle passes without one. Cases that must raise no interrupt are covered by the same rule. Their effect on the registers is then read through the capture outputs.

// File: rtl/dct_pkg.sv
package dct_pkg;
  localparam int unsigned NCH  = 2;
  localparam int unsigned NTRG = 3;

  // trigger slots
  localparam int unsigned TRG_A    = 0;
  localparam int unsigned TRG_AREV = 1;
  localparam int unsigned TRG_B    = 2;

  typedef struct packed {
    logic load;
    logic arm;
  } chan_ctl_t;
endpackage

// File: rtl/dct_counter.sv
module dct_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/dct_trig_hold.sv
// Holds a qualified edge until the next falling-phase strobe.
module dct_trig_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic allow_i,
  input  logic edge_i,
  input  logic take_i,
  output logic fire_o
);
  logic pend_q;
  logic hit;

  assign hit    = run_i & allow_i & edge_i;
  assign fire_o = run_i & take_i & (pend_q | hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= 1'b0;
    else if (!run_i) pend_q <= 1'b0;
    else if (take_i) pend_q <= 1'b0;
    else if (hit)    pend_q <= 1'b1;
  end
endmodule

// File: rtl/dct_chan.sv
module dct_chan #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         load_i,
  input  logic         arm_i,
  input  logic         rise_i,
  input  logic [W-1:0] cnt_i,
  output logic [W-1:0] cap_o,
  output logic         irq_o
);
  logic [W-1:0] cap_q;
  logic         armed_q;
  logic         irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cap_q <= '0;
    else if (load_i) cap_q <= cnt_i;
  end

  // a second arm before the rising phase merges into one pulse
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      irq_q   <= 1'b0;
    end else if (!run_i) begin
      armed_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= rise_i & armed_q;
      if (arm_i)       armed_q <= 1'b1;
      else if (rise_i) armed_q <= 1'b0;
    end
  end

  assign cap_o = cap_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/dual_capture_timer.sv
module dual_capture_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_rise_i,
  input  logic             tick_fall_i,
  input  logic             edge_a_i,
  input  logic             edge_a_rev_i,
  input  logic             edge_b_i,
  input  logic             rev_mode_i,
  input  logic             a_is_clk_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] cap0_o,
  output logic [CNT_W-1:0] cap1_o,
  output logic             irq0_o,
  output logic             irq1_o
);
  import dct_pkg::*;

  logic [CNT_W-1:0]         cnt;
  logic [NTRG-1:0]          trg_edge;
  logic [NTRG-1:0]          trg_allow;
  logic [NTRG-1:0]          trg_fire;
  chan_ctl_t [NCH-1:0]      ctl;
  logic [NCH-1:0][CNT_W-1:0] cap;
  logic [NCH-1:0]           irq;

  dct_counter #(.W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_i),
    .tick_i (tick_rise_i),
    .cnt_o  (cnt)
  );

  assign trg_edge[TRG_A]     = edge_a_i;
  assign trg_edge[TRG_AREV]  = edge_a_rev_i;
  assign trg_edge[TRG_B]     = edge_b_i;
  assign trg_allow[TRG_A]    = ~a_is_clk_i;
  assign trg_allow[TRG_AREV] = ~a_is_clk_i & rev_mode_i;
  assign trg_allow[TRG_B]    = 1'b1;

  for (genvar t = 0; t < NTRG; t++) begin : g_trg
    dct_trig_hold u_hold (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .run_i   (run_i),
      .allow_i (trg_allow[t]),
      .edge_i  (trg_edge[t]),
      .take_i  (tick_fall_i),
      .fire_o  (trg_fire[t])
    );
  end

  // reg 0: B loads normally; in reverse mode A-rev loads silently, B only interrupts
  always_comb begin
    ctl[0].load = rev_mode_i ? trg_fire[TRG_AREV] : trg_fire[TRG_B];
    ctl[0].arm  = trg_fire[TRG_B];
    ctl[1].load = trg_fire[TRG_A];
    ctl[1].arm  = trg_fire[TRG_A];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dct_chan #(.W(CNT_W)) u_ch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (run_i),
      .load_i (ctl[c].load),
      .arm_i  (ctl[c].arm),
      .rise_i (tick_rise_i),
      .cnt_i  (cnt),
      .cap_o  (cap[c]),
      .irq_o  (irq[c])
    );
  end

  assign count_o = cnt;
  assign cap0_o  = cap[0];
  assign cap1_o  = cap[1];
  assign irq0_o  = irq[0];
  assign irq1_o  = irq[1];
endmodule

// File: rtl/dual_capture_timer_chk.sv
module dual_capture_timer_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_i,
  input logic             tick_rise_i,
  input logic [CNT_W-1:0] count_o,
  input logic [CNT_W-1:0] cap0_o,
  input logic [CNT_W-1:0] cap1_o,
  input logic             irq0_o,
  input logic             irq1_o
);
  // R1
  cnt_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> count_o == '0);

  // R1
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_rise_i) |=> $stable(count_o));

  // R1
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_rise_i) |=> count_o == $past(count_o) + CNT_W'(1));

  // R4
  irq_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq0_o || irq1_o) |-> $past(tick_rise_i));

  // R4
  irq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq0_o || irq1_o) |-> !tick_rise_i || !$past(tick_rise_i, 2));

  // R8
  stop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(cap0_o) && $stable(cap1_o) && !irq0_o && !irq1_o);
endmodule

bind dual_capture_timer dual_capture_timer_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/dual_capture_timer_tb_top.sv
`timescale 1ns/1ps
module dual_capture_timer_tb_top;
  localparam int NRISE = 4;  // capture edge to interrupt edge in AUTO mode

  typedef struct {
    logic [15:0] val;
    int          due;
  } item_t;

  logic clk = 1'b0;
  logic rst_n, run, rise, fall, ea, earev, eb, rev, aclk;
  logic [15:0] count, cap0, cap1;
  logic irq0, irq1;

  int mode = 0;  // 0 auto, 1 fast, 2 manual
  int ph = 0;
  int cyc = 0;
  int tests = 0, fails = 0;
  bit done = 1'b0;
  logic [15:0] exp_cnt, exp_cap0, exp_cap1;
  item_t q0[$], q1[$];

  always #4 clk = ~clk;

  dual_capture_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run),
    .tick_rise_i(rise), .tick_fall_i(fall),
    .edge_a_i(ea), .edge_a_rev_i(earev), .edge_b_i(eb),
    .rev_mode_i(rev), .a_is_clk_i(aclk),
    .count_o(count), .cap0_o(cap0), .cap1_o(cap1),
    .irq0_o(irq0), .irq1_o(irq1)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) exp_cnt <= '0;
    else if (!run) exp_cnt <= '0;
    else if (rise) exp_cnt <= exp_cnt + 16'd1;

  always @(negedge clk) begin
    if (mode == 0) begin
      ph   <= (ph + 1) % 8;
      rise <= ((ph + 1) % 8 == 0);
      fall <= ((ph + 1) % 8 == 4);
    end else if (mode == 1) begin
      rise <= 1'b1;
      fall <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (irq0) begin
        if (q0.size() == 0) chk(0, "R4/R6", "irq0 unexpected", cyc, -1);
        else begin
          chk(cyc == q0[0].due, "R4", "irq0 cycle", cyc, q0[0].due);
          chk(cap0 == q0[0].val, "R3/R7", "cap0 at irq0", cap0, q0[0].val);
          void'(q0.pop_front());
        end
      end else if (q0.size() != 0 && cyc > q0[0].due) begin
        chk(0, "R4", "irq0 missed", cyc, q0[0].due);
        void'(q0.pop_front());
      end
      if (irq1) begin
        if (q1.size() == 0) chk(0, "R4/R9", "irq1 unexpected", cyc, -1);
        else begin
          chk(cyc == q1[0].due, "R4", "irq1 cycle", cyc, q1[0].due);
          chk(cap1 == q1[0].val, "R2", "cap1 at irq1", cap1, q1[0].val);
          void'(q1.pop_front());
        end
      end else if (q1.size() != 0 && cyc > q1[0].due) begin
        chk(0, "R4", "irq1 missed", cyc, q1[0].due);
        void'(q1.pop_front());
      end
    end
  end

  // driver: kind 0 = A, 1 = A reverse-phase, 2 = B (AUTO mode)
  task automatic fire(input int kind);
    item_t it;
    @(negedge clk);
    case (kind)
      0: ea = 1'b1;
      1: earev = 1'b1;
      default: eb = 1'b1;
    endcase
    @(posedge clk); #1;
    ea = 1'b0; earev = 1'b0; eb = 1'b0;
    while (!fall) begin @(posedge clk); #1; end
    if (run) begin
      it.due = cyc + NRISE;
      if (kind == 0 && !aclk) begin
        exp_cap1 = exp_cnt;
        it.val = exp_cap1;
        q1.push_back(it);
      end else if (kind == 1 && rev && !aclk) begin
        exp_cap0 = exp_cnt;
      end else if (kind == 2) begin
        if (!rev) exp_cap0 = exp_cnt;
        it.val = exp_cap0;
        q0.push_back(it);
      end
    end
  endtask

  task automatic drain(input string req);
    repeat (12) @(negedge clk);
    chk(q0.size() == 0 && q1.size() == 0, req, "pending interrupts", q0.size() + q1.size(), 0);
    chk(cap0 == exp_cap0, req, "cap0", cap0, exp_cap0);
    chk(cap1 == exp_cap1, req, "cap1", cap1, exp_cap1);
  endtask

  task automatic set_mode(input int m);
    @(posedge clk); #1;
    mode = m;
    if (m == 2) begin rise = 1'b0; fall = 1'b0; end
  endtask

  initial begin
    rst_n = 1'b0; run = 1'b0; rise = 1'b0; fall = 1'b0;
    ea = 1'b0; earev = 1'b0; eb = 1'b0; rev = 1'b0; aclk = 1'b0;
    exp_cap0 = '0; exp_cap1 = '0;
    repeat (3) @(negedge clk);
    // R10
    chk(count == 0 && cap0 == 0 && cap1 == 0, "R10", "reset regs", count | cap0 | cap1, 0);
    chk(!irq0 && !irq1, "R10", "reset irqs", {irq0, irq1}, 0);
    rst_n = 1'b1;

    // R1 counting
    @(negedge clk); run = 1'b1;
    repeat (30) @(negedge clk);
    chk(count == exp_cnt && exp_cnt != 0, "R1", "count running", count, exp_cnt);

    // R2 / R3 / R4 at varied phases
    for (int k = 0; k < 4; k++) begin
      repeat (k) @(negedge clk);
      fire(0);
      repeat (k + 1) @(negedge clk);
      fire(2);
    end
    drain("R2");
    fire(2);
    drain("R3");

    // R8 stopped
    @(negedge clk); run = 1'b0;
    @(negedge clk);
    chk(count == 0, "R1", "count cleared", count, 0);
    fire(0); fire(2); fire(0);
    @(negedge clk); eb = 1'b1; ea = 1'b1;
    @(negedge clk); eb = 1'b0; ea = 1'b0; run = 1'b1;
    repeat (20) @(negedge clk);
    drain("R8");

    // R6 / R7 reverse-phase mode
    @(negedge clk); rev = 1'b1;
    fire(1);
    drain("R6");
    fire(2);
    drain("R7");
    @(negedge clk); rev = 1'b0;
    fire(1);
    drain("R6");

    // R9 A used as count clock
    @(negedge clk); aclk = 1'b1;
    fire(0);
    drain("R9");
    @(negedge clk); rev = 1'b1;
    fire(1);
    fire(2);
    drain("R9");
    @(negedge clk); rev = 1'b0; aclk = 1'b0;
    fire(2);
    drain("R9");

    // R5 double capture before the rising phase
    set_mode(2);
    @(negedge clk); eb = 1'b1; fall = 1'b1;
    @(negedge clk); eb = 1'b0; fall = 1'b0;
    repeat (2) @(negedge clk);
    eb = 1'b1; fall = 1'b1;
    @(negedge clk); eb = 1'b0; fall = 1'b0;
    exp_cap0 = exp_cnt;
    @(negedge clk);
    rise = 1'b1;
    begin
      item_t it;
      it.val = exp_cap0;
      it.due = cyc + 1;
      q0.push_back(it);
    end
    @(negedge clk); rise = 1'b0;
    drain("R5");

    // R1 wrap
    @(negedge clk); run = 1'b0;
    set_mode(1);
    @(negedge clk); run = 1'b1;
    while (exp_cnt != 16'hFFFF) @(negedge clk);
    chk(count == 16'hFFFF, "R1", "count at max", count, 16'hFFFF);
    @(negedge clk);
    chk(count == 16'h0000, "R1", "count wrapped", count, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 200000);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule